// File: doc/BRIEF.md
# Sample-Packing Slave FIFO Write Master

This block accepts a stream of 8-bit samples, one per clock at most, gathers four consecutive samples into a 32-bit word and writes each word into an external synchronous slave-FIFO peripheral. All signals are timed to the single interface clock. Each word sits in a small internal buffer until the peripheral's two ready flags both report space. Once they do, the block runs a fixed setup-then-strobe write on the active-low bus.

A stop request closes the current packet. Any partly filled word is zero-padded and written with the packet-end strobe in the same cycle. If no samples are pending, a packet-end strobe is issued on its own. A sticky overflow flag records any word that had to be discarded because the buffer was full. The read strobe and output enable belong to the opposite direction and are held inactive.

Top module: `sfifo_pack_writer`

## Requirements
- R1: While reset is asserted and after it is released with no input activity, cs_n, wr_n, pktend_n, rd_n and oe_n are high, the bus data is zero and overflow is low.
- R2: The first accepted sample of a group lands in bits 7:0 and the next three in bits 15:8, 23:16 and 31:24. Words reach the bus in the order they were formed, and none is lost while the buffer has room.
- R3: If a word completes (or a stop request forms an entry) while all DEPTH buffer entries are occupied and none is leaving in that cycle, that entry is discarded. In that case overflow goes high and stays high until reset.
- R4: A transfer starts (cs_n falls) only in the cycle after a cycle in which both fifo_rdy_a and fifo_rdy_b were high. While either flag stays low, cs_n stays high.
- R5: Every write has one setup cycle with cs_n low, wr_n high and the word on the data bus. It is followed by one strobe cycle with cs_n low, wr_n low and the same data. After that, cs_n returns high.
- R6: rd_n and oe_n are always high.
- R7: fifo_addr always carries the FIFO_ADDR parameter value (3 in the bench).
- R8: A stop request with at least one pending sample writes the zero-padded word with pktend_n low in the same strobe cycle as wr_n.
- R9: A stop request with no pending sample and no sample in the same cycle produces a strobe cycle with pktend_n low, cs_n low and wr_n high.
- R10: A sample presented in the same cycle as a stop request is included in the final word of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 8 | Sample value |
| stop_req | input | 1 | Close the current packet |
| fifo_rdy_a | input | 1 | Peripheral ready flag A, high = space |
| fifo_rdy_b | input | 1 | Peripheral ready flag B, high = space |
| fifo_cs_n | output | 1 | Chip select, active low |
| fifo_wr_n | output | 1 | Write strobe, active low |
| fifo_rd_n | output | 1 | Read strobe, held high |
| fifo_oe_n | output | 1 | Output enable, held high |
| fifo_pktend_n | output | 1 | Packet end strobe, active low |
| fifo_addr | output | 2 | FIFO select address |
| fifo_data | output | 32 | Write data bus |
| overflow | output | 1 | Sticky: a packed word was discarded |

## Verification
A packer lane pointer that slips shows up as bytes in the wrong lanes of the very next word on the bus. A buffer pointer fault shows up as a repeated or skipped word within DEPTH transfers. A sequencer stuck in the wrong state is visible at once, as a strobe without a setup cycle or chip select held low past the strobe. A wrong occupancy count appears either as a false overflow or as a lost word once the ready flags are held low long enough to fill the buffer.

// File: rtl/sfpw_pkg.sv
package sfpw_pkg;
  localparam int SMP_W  = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = SMP_W * LANES;

  // One buffered entry: a packed word plus its framing tags.
  typedef struct packed {
    logic              no_data;  // packet end only, no write strobe
    logic              last;     // packet end accompanies this entry
    logic [WORD_W-1:0] word;
  } entry_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sfpw_packer.sv
module sfpw_packer
  import sfpw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_data,
  input  logic             in_stop,
  output logic             push,
  output entry_t           push_entry
);
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CW-1:0]     fill_q, fill_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] merged;
  logic              word_done;

  always_comb begin
    merged = acc_q;
    for (int i = 0; i < LANES; i++) begin
      if (in_valid && (fill_q == CW'(i))) begin
        merged[i*SMP_W +: SMP_W] = in_data;
      end
    end
  end

  assign word_done = in_valid && (fill_q == CW'(LANES - 1));
  assign push      = in_stop || word_done;

  always_comb begin
    push_entry.word    = merged;
    push_entry.last    = in_stop;
    push_entry.no_data = in_stop && !in_valid && (fill_q == '0);
  end

  always_comb begin
    acc_d  = acc_q;
    fill_d = fill_q;
    if (push) begin
      acc_d  = '0;
      fill_d = '0;
    end else if (in_valid) begin
      acc_d  = merged;
      fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (push || in_valid) begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/sfpw_buffer.sv
module sfpw_buffer
  import sfpw_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  entry_t push_entry,
  input  logic   pop,
  output entry_t head,
  output logic   empty,
  output logic   full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  entry_t        mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [NW-1:0] used_q, used_d;
  logic          wr_en, rd_en;

  assign empty = (used_q == '0);
  assign full  = (used_q == NW'(DEPTH));
  assign rd_en = pop && !empty;
  assign wr_en = push && (!full || rd_en);
  assign head  = mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wr_en ? bump(wptr_q) : wptr_q;
    rptr_d = rd_en ? bump(rptr_q) : rptr_q;
    used_d = used_q;
    if (wr_en && !rd_en) used_d = used_q + 1'b1;
    else if (rd_en && !wr_en) used_d = used_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      used_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      used_q <= used_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wptr_q == AW'(g))) begin
        mem[g] <= push_entry;
      end
    end
  end
endmodule

// File: rtl/sfpw_bus_seq.sv
module sfpw_bus_seq
  import sfpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_a,
  input  logic              rdy_b,
  input  logic              buf_empty,
  input  entry_t            head,
  output logic              pop,
  output logic              cs_n,
  output logic              wr_n,
  output logic              pktend_n,
  output logic [WORD_W-1:0] data
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:   if (!buf_empty && rdy_a && rdy_b) state_d = SQ_SETUP;
      SQ_SETUP:  state_d = SQ_STROBE;
      SQ_STROBE: state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    cs_n     = 1'b1;
    wr_n     = 1'b1;
    pktend_n = 1'b1;
    data     = '0;
    pop      = 1'b0;
    if (state_q == SQ_SETUP) begin
      cs_n = 1'b0;
      data = head.word;
    end else if (state_q == SQ_STROBE) begin
      cs_n     = 1'b0;
      data     = head.word;
      wr_n     = head.no_data;
      pktend_n = !head.last;
      pop      = 1'b1;
    end
  end
endmodule

// File: rtl/sfifo_pack_writer.sv
module sfifo_pack_writer
  import sfpw_pkg::*;
#(
  parameter int         DEPTH     = 4,
  parameter logic [1:0] FIFO_ADDR = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              stop_req,
  input  logic              fifo_rdy_a,
  input  logic              fifo_rdy_b,
  output logic              fifo_cs_n,
  output logic              fifo_wr_n,
  output logic              fifo_rd_n,
  output logic              fifo_oe_n,
  output logic              fifo_pktend_n,
  output logic [1:0]        fifo_addr,
  output logic [WORD_W-1:0] fifo_data,
  output logic              overflow
);
  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic   push, pop, buf_empty, buf_full;
  entry_t push_entry, head;
  logic   ovf_q, ovf_d;

  sfpw_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (smp_valid),
    .in_data    (smp_data),
    .in_stop    (stop_req),
    .push       (push),
    .push_entry (push_entry)
  );

  sfpw_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (push),
    .push_entry (push_entry),
    .pop        (pop),
    .head       (head),
    .empty      (buf_empty),
    .full       (buf_full)
  );

  sfpw_bus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rdy_a     (fifo_rdy_a),
    .rdy_b     (fifo_rdy_b),
    .buf_empty (buf_empty),
    .head      (head),
    .pop       (pop),
    .cs_n      (fifo_cs_n),
    .wr_n      (fifo_wr_n),
    .pktend_n  (fifo_pktend_n),
    .data      (fifo_data)
  );

  assign ovf_d = ovf_q || (push && buf_full && !pop);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovf_q <= 1'b0;
    else            ovf_q <= ovf_d;
  end

  assign overflow  = ovf_q;
  assign fifo_rd_n = 1'b1;
  assign fifo_oe_n = 1'b1;
  assign fifo_addr = FIFO_ADDR;
endmodule

// File: rtl/sfpw_checker.sv
module sfpw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rdy_a,
  input logic        rdy_b,
  input logic        cs_n,
  input logic        wr_n,
  input logic        rd_n,
  input logic        oe_n,
  input logic        pktend_n,
  input logic [31:0] data,
  input logic        overflow
);
  p_read_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n && oe_n);

  p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(rdy_a && rdy_b));

  p_strobe_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_n && $past(!cs_n && wr_n) && $stable(data)));

  p_strobe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !pktend_n) |=> (cs_n && wr_n && pktend_n));

  p_pktend_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |-> (!cs_n && $past(!cs_n && wr_n && pktend_n)));

  p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind sfifo_pack_writer sfpw_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdy_a    (fifo_rdy_a),
  .rdy_b    (fifo_rdy_b),
  .cs_n     (fifo_cs_n),
  .wr_n     (fifo_wr_n),
  .rd_n     (fifo_rd_n),
  .oe_n     (fifo_oe_n),
  .pktend_n (fifo_pktend_n),
  .data     (fifo_data),
  .overflow (overflow)
);

// File: tb/sfifo_pack_writer_test.sv
module sfifo_pack_writer_test;
  localparam int         DEPTH = 4;
  localparam logic [1:0] ADDR  = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        stop_req = 1'b0;
  logic        fifo_rdy_a = 1'b1;
  logic        fifo_rdy_b = 1'b1;
  logic        fifo_cs_n, fifo_wr_n, fifo_rd_n, fifo_oe_n, fifo_pktend_n;
  logic [1:0]  fifo_addr;
  logic [31:0] fifo_data;
  logic        overflow;

  sfifo_pack_writer #(.DEPTH(DEPTH), .FIFO_ADDR(ADDR)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .stop_req(stop_req), .fifo_rdy_a(fifo_rdy_a), .fifo_rdy_b(fifo_rdy_b),
    .fifo_cs_n(fifo_cs_n), .fifo_wr_n(fifo_wr_n), .fifo_rd_n(fifo_rd_n),
    .fifo_oe_n(fifo_oe_n), .fifo_pktend_n(fifo_pktend_n),
    .fifo_addr(fifo_addr), .fifo_data(fifo_data), .overflow(overflow)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int pushed = 0;
  int seen = 0;
  int cs_low_cnt = 0;
  bit rand_flags = 1'b0;
  bit exp_ovf = 1'b0;
  int bcnt = 0;
  logic [31:0] macc = '0;
  logic [33:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Expected entry tag: {no_data, last, word}
  function automatic logic [33:0] make_entry(input bit nd, input bit lst,
                                             input logic [31:0] w);
    return {nd, lst, w};
  endfunction

  function automatic logic [31:0] put_lane(input logic [31:0] w, input int lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  task automatic model(input bit v, input logic [7:0] b, input bit s,
                       input bit allow_drop);
    bit nd;
    nd = s && !v && (bcnt == 0);
    if (v) begin
      macc = put_lane(macc, bcnt, b);
      bcnt++;
    end
    if (s || bcnt == 4) begin
      if (allow_drop && (pushed - seen >= DEPTH)) exp_ovf = 1'b1;
      else begin
        exp_q.push_back(make_entry(nd, s, macc));
        pushed++;
      end
      macc = '0;
      bcnt = 0;
    end
  endtask

  task automatic drive(input bit v, input logic [7:0] b, input bit s);
    smp_valid = v;
    smp_data  = b;
    stop_req  = s;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    stop_req  = 1'b0;
  endtask

  task automatic send(input bit v, input logic [7:0] b, input bit s, input bit gate);
    bit will_push;
    will_push = s || (v && bcnt == 3);
    if (gate && will_push) begin
      while (pushed - seen >= DEPTH) drive(1'b0, 8'h00, 1'b0);
    end
    model(v, b, s, !gate);
    drive(v, b, s);
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) drive(1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) drive(1'b0, 8'h00, 1'b0);
  endtask

  // Bus monitor, sampled on the falling edge.
  logic        prev_cs_n = 1'b1, prev_wr_n = 1'b1;
  logic [31:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fifo_cs_n) cs_low_cnt++;
      if (!fifo_cs_n && (!fifo_wr_n || !fifo_pktend_n)) begin
        logic [33:0] e;
        seen++;
        check(prev_cs_n == 1'b0 && prev_wr_n == 1'b1 && prev_data == fifo_data,
              "R5", "setup cycle before strobe", {prev_cs_n, prev_wr_n}, 2'b01);
        check(fifo_rd_n && fifo_oe_n, "R6", "read side idle",
              {fifo_rd_n, fifo_oe_n}, 2'b11);
        check(fifo_addr == ADDR, "R7", "fifo address", fifo_addr, ADDR);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected transfer", fifo_data, 0);
        end else begin
          e = exp_q.pop_front();
          if (e[33]) begin
            check(fifo_wr_n == 1'b1 && fifo_pktend_n == 1'b0, "R9",
                  "packet end without data", {fifo_wr_n, fifo_pktend_n}, 2'b10);
          end else begin
            check(fifo_wr_n == 1'b0, "R5", "write strobe", fifo_wr_n, 0);
            check(fifo_data == e[31:0], "R2", "packed word", fifo_data, e[31:0]);
            check(fifo_pktend_n == !e[32], "R8", "packet end with word",
                  fifo_pktend_n, !e[32]);
          end
        end
      end
      prev_cs_n = fifo_cs_n;
      prev_wr_n = fifo_wr_n;
      prev_data = fifo_data;
    end
  end

  initial begin : flag_gen
    forever begin
      @(posedge clk);
      #1;
      if (rand_flags) begin
        fifo_rdy_a = ($urandom % 8) != 0;
        fifo_rdy_b = ($urandom % 8) != 0;
      end
    end
  end

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1;
    check(fifo_cs_n && fifo_wr_n && fifo_pktend_n && fifo_rd_n && fifo_oe_n,
          "R1", "strobes idle in reset", {fifo_cs_n, fifo_wr_n, fifo_pktend_n}, 3'b111);
    check(fifo_data == 0 && !overflow, "R1", "data and overflow in reset",
          {overflow, fifo_data}, 0);
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 8'h00, 1'b0);
    check(fifo_cs_n && !overflow, "R1", "idle after release", {fifo_cs_n, overflow}, 2'b10);

    // Directed: one full word, lane order.
    send(1, 8'h11, 0, 1); send(1, 8'h22, 0, 1); send(1, 8'h33, 0, 1); send(1, 8'h44, 0, 1);
    // R10: stop together with a sample.
    send(1, 8'hA1, 0, 1); send(1, 8'hB2, 1, 1);
    // R9: stop with nothing pending.
    send(0, 8'h00, 1, 1);
    // R8: single pending sample then stop.
    send(1, 8'h5C, 0, 1); send(0, 8'h00, 1, 1);
    // R10 corner: fourth sample with stop.
    send(1, 8'h01, 0, 1); send(1, 8'h02, 0, 1); send(1, 8'h03, 0, 1); send(1, 8'h04, 1, 1);
    drain();
    check(exp_q.size() == 0, "R2", "directed words delivered", exp_q.size(), 0);

    // Random stimulus with random ready flags.
    rand_flags = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      send(($urandom % 10) < 6, 8'($urandom), ($urandom % 40) == 0, 1);
    end
    send(0, 8'h00, 1, 1);
    rand_flags = 1'b0;
    #0;
    fifo_rdy_a = 1'b1;
    fifo_rdy_b = 1'b1;
    drain();
    check(exp_q.size() == 0, "R2", "random words delivered", exp_q.size(), 0);
    check(overflow == 1'b0, "R3", "no overflow with room", overflow, 0);

    // R4 / R3: flags low, fill the buffer beyond its depth.
    fifo_rdy_a = 1'b0;
    fifo_rdy_b = 1'b1;
    repeat (3) drive(1'b0, 8'h00, 1'b0);
    cs_low_cnt = 0;
    for (int k = 0; k < 4 * (DEPTH + 1); k++) send(1, 8'(k + 8'h70), 0, 0);
    repeat (6) drive(1'b0, 8'h00, 1'b0);
    check(cs_low_cnt == 0, "R4", "no transfer while flag low", cs_low_cnt, 0);
    check(overflow == 1'b1 && exp_ovf, "R3", "overflow after full buffer", overflow, 1);
    fifo_rdy_a = 1'b1;
    drain();
    check(exp_q.size() == 0, "R3", "buffered words kept", exp_q.size(), 0);
    check(overflow == 1'b1, "R3", "overflow sticky", overflow, 1);

    // Reset clears the sticky flag.
    rst_n = 1'b0;
    repeat (2) drive(1'b0, 8'h00, 1'b0);
    check(overflow == 1'b0 && fifo_cs_n, "R1", "reset clears overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (3) drive(1'b0, 8'h00, 1'b0);
    finish_run();
  end
endmodule